// File: doc/BRIEF.md
# Delayed Write Parity Checker

This block is the target-side parity checker for delayed writes at one bridge port. It holds a single queued delayed write: the address, data, byte enables and parity captured from the first attempt, plus the completion status that arrives later from the far bus. When the initiator repeats the write, the block decides whether to retry it or accept the data. It then checks the parity that follows the data phase and compares the repeated data and parity with the stored copy. Only an exact, clean match returns the stored status and frees the entry.

Parity errors are reported in two ways. An error seen on the initiator bus sets a sticky detected bit and, when the near-side response enable is on, pulses the active-low error line. A parity error that the far bus reported for the queued write is passed back to the initiator on the same error line. This happens only when both the near-side and far-side response enables are set, and the write still completes normally.

Handshakes are simplified to a single data phase. A request cycle presents address, byte enables and data. The block answers in the next cycle with either a data-accept strobe or a retry strobe. The parity bit for that data phase is presented one cycle after it.

Top module: `dw_parity_guard`

## Requirements
- R1: After reset, trdy_n, stop_n and perr_n are high, perr_oe, pe_det, st_ret and st_far_perr are low, and ent_full is low.
- R2: A request (req_vld high in the idle state) is retried when no entry is held, when the far completion has not yet arrived, or when req_addr or req_be differ from the stored entry. Retry means stop_n is low for exactly the one cycle after the request, with trdy_n held high. The entry is left unchanged.
- R3: A request that matches the stored address and byte enables of an entry with a completion present is accepted: trdy_n is low for exactly the one cycle after the request, and stop_n stays high.
- R4: Parity is even over the 32 data bits and 4 byte-enable bits, so the correct par_in equals the XOR of {req_data, req_be}. par_in is sampled one cycle after the accept cycle. A wrong value sets pe_det from the next cycle onward, whatever the response enables are.
- R5: The error line reports an event in a fixed three-cycle pattern. perr_n is low for exactly one cycle, two cycles after the accept cycle. In the following cycle perr_oe stays high with perr_n high. In the cycle after that perr_oe drops. An initiator-bus parity error produces this pattern only when pere_near is set.
- R6: If the repeated write has a parity error, or its data or parity differ from the stored copy, st_ret stays low and ent_full stays high.
- R7: An exact data and parity match with correct parity pulses st_ret for one cycle, three cycles after the request cycle. ent_full is low from that cycle on.
- R8: st_ret carries the far-bus error in st_far_perr. For a clean initiator write whose far completion reported an error, perr_n follows the R5 pattern only when both pere_near and pere_far are high.
- R9: pe_det stays set until a one-cycle pulse on pe_det_clr clears it.
- R10: A load (ld_vld) while an entry is held is ignored. A completion (cmp_vld) arriving with no entry held is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_vld | input | 1 | Capture a new delayed write into the entry |
| ld_addr | input | 32 | Address of the captured write |
| ld_be | input | 4 | Byte enables of the captured write |
| ld_data | input | 32 | Data of the captured write |
| ld_par | input | 1 | Parity of the captured write |
| cmp_vld | input | 1 | Far-bus completion for the held entry |
| cmp_far_perr | input | 1 | Far bus reported a parity error |
| req_vld | input | 1 | Initiator repeats a write (request cycle) |
| req_addr | input | 32 | Address of the repeated write |
| req_be | input | 4 | Byte enables of the repeated write |
| req_data | input | 32 | Data of the repeated write |
| par_in | input | 1 | Parity, valid one cycle after the accept cycle |
| pere_near | input | 1 | Parity-error response enable, initiator side |
| pere_far | input | 1 | Parity-error response enable, far side |
| pe_det_clr | input | 1 | Write-one-to-clear pulse for pe_det |
| trdy_n | output | 1 | Data accept strobe, active low |
| stop_n | output | 1 | Retry strobe, active low |
| perr_n | output | 1 | Parity error line, active low |
| perr_oe | output | 1 | Drive enable for perr_n |
| pe_det | output | 1 | Sticky parity-error-detected status |
| st_ret | output | 1 | Stored write status returned (one cycle) |
| st_far_perr | output | 1 | Far-bus error flag of the returned status |
| ent_full | output | 1 | An entry is held |

## Verification
The assertions rely on a few assumptions about the inputs. A new request arrives only once the previous one has ended, so error-line events are at least three cycles apart and never overlap. The far completion never lands in the same cycle that frees the entry. The stimulus keeps to both rules: it waits out the full request, parity and error-line sequence before starting the next transaction, and it sends completions only while no request is in flight.

// File: rtl/dwp_pkg.sv
`timescale 1ns/1ps
package dwp_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_DATA = 2'd1,
    TS_RTRY = 2'd2,
    TS_PARW = 2'd3
  } tgt_state_e;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } perr_phase_e;
endpackage

// File: rtl/dwp_entry.sv
`timescale 1ns/1ps
module dwp_entry #(
  parameter  int AW = 32,
  parameter  int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_vld,
  input  logic [AW-1:0] ld_addr,
  input  logic [BW-1:0] ld_be,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_par,
  input  logic          cmp_vld,
  input  logic          cmp_far_perr,
  input  logic          free,
  output logic          e_full,
  output logic          e_avail,
  output logic          e_far,
  output logic [AW-1:0] e_addr,
  output logic [BW-1:0] e_be,
  output logic [DW-1:0] e_data,
  output logic          e_par
);
  logic full_q, full_d;
  logic avail_q, avail_d;
  logic far_q, far_d;
  logic ld_en, cmp_en;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] be_q;
  logic [DW-1:0] data_q;
  logic          par_q;

  assign ld_en  = ld_vld && !full_q && !free;
  assign cmp_en = cmp_vld && full_q && !free;

  always_comb begin
    full_d  = full_q;
    avail_d = avail_q;
    far_d   = far_q;
    if (free) begin
      full_d  = 1'b0;
      avail_d = 1'b0;
      far_d   = 1'b0;
    end else if (ld_en) begin
      full_d  = 1'b1;
      avail_d = 1'b0;
      far_d   = 1'b0;
    end else if (cmp_en) begin
      avail_d = 1'b1;
      far_d   = cmp_far_perr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      avail_q <= 1'b0;
      far_q   <= 1'b0;
    end else begin
      full_q  <= full_d;
      avail_q <= avail_d;
      far_q   <= far_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      be_q   <= '0;
      data_q <= '0;
      par_q  <= 1'b0;
    end else if (ld_en) begin
      addr_q <= ld_addr;
      be_q   <= ld_be;
      data_q <= ld_data;
      par_q  <= ld_par;
    end
  end

  assign e_full  = full_q;
  assign e_avail = avail_q;
  assign e_far   = far_q;
  assign e_addr  = addr_q;
  assign e_be    = be_q;
  assign e_data  = data_q;
  assign e_par   = par_q;

  AST_LOAD_WHEN_FULL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && ld_vld && !free) |=> ($stable(addr_q) && $stable(data_q))); // R10
  AST_AVAIL_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    avail_q |-> full_q); // R2
endmodule

// File: rtl/dwp_tgt.sv
`timescale 1ns/1ps
module dwp_tgt
  import dwp_pkg::*;
#(
  parameter  int AW = 32,
  parameter  int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] req_be,
  input  logic [DW-1:0] req_data,
  input  logic          par_in,
  input  logic          e_full,
  input  logic          e_avail,
  input  logic          e_far,
  input  logic [AW-1:0] e_addr,
  input  logic [BW-1:0] e_be,
  input  logic [DW-1:0] e_data,
  input  logic          e_par,
  output logic          trdy_n,
  output logic          stop_n,
  output logic          ini_err,
  output logic          done,
  output logic          far_pass,
  output logic          st_ret,
  output logic          st_far
);
  tgt_state_e st_q, st_d;
  logic [DW-1:0] rdata_q;
  logic [BW-1:0] rbe_q;
  logic          take;
  logic          hit;
  logic          eval;
  logic          bad_par;
  logic [BW-1:0] lane_eq;
  logic          data_eq;
  logic          ret_q, far_q;

  assign hit  = e_full && e_avail && (req_addr == e_addr) && (req_be == e_be);
  assign take = (st_q == TS_IDLE) && req_vld;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TS_IDLE: if (req_vld) st_d = hit ? TS_DATA : TS_RTRY;
      TS_DATA: st_d = TS_PARW;
      TS_RTRY: st_d = TS_IDLE;
      TS_PARW: st_d = TS_IDLE;
      default: st_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rbe_q   <= '0;
    end else if (take) begin
      rdata_q <= req_data;
      rbe_q   <= req_be;
    end
  end

  for (genvar b = 0; b < BW; b++) begin : g_lane
    assign lane_eq[b] = (rdata_q[8*b +: 8] == e_data[8*b +: 8]);
  end
  assign data_eq = &lane_eq;

  assign eval     = (st_q == TS_PARW);
  assign bad_par  = par_in != (^{rdata_q, rbe_q});
  assign ini_err  = eval && bad_par;
  assign done     = eval && !bad_par && data_eq && (par_in == e_par);
  assign far_pass = done && e_far;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_q <= 1'b0;
      far_q <= 1'b0;
    end else begin
      ret_q <= done;
      far_q <= far_pass;
    end
  end

  assign trdy_n = (st_q != TS_DATA);
  assign stop_n = (st_q != TS_RTRY);
  assign st_ret = ret_q;
  assign st_far = far_q;

  AST_STOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |=> stop_n); // R2
  AST_TRDY_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> (e_full && e_avail)); // R3
  AST_RET_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    st_ret |-> ($past(trdy_n, 2) == 1'b0)); // R7
  AST_NO_RET_ON_PERR: assert property (@(posedge clk) disable iff (!rst_n)
    ini_err |=> !st_ret); // R6
endmodule

// File: rtl/dwp_perr.sv
`timescale 1ns/1ps
module dwp_perr
  import dwp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ini_err,
  input  logic far_pass,
  input  logic pere_near,
  input  logic pere_far,
  input  logic pe_clr,
  output logic perr_n,
  output logic perr_oe,
  output logic pe_det
);
  perr_phase_e ph_q, ph_d;
  logic fire;
  logic pe_q, pe_d;

  assign fire = (ini_err && pere_near) || (far_pass && pere_near && pere_far);

  always_comb begin
    ph_d = ph_q;
    if (fire) ph_d = PH_LOW;
    else begin
      unique case (ph_q)
        PH_LOW:  ph_d = PH_HIGH;
        PH_HIGH: ph_d = PH_OFF;
        default: ph_d = PH_OFF;
      endcase
    end
    pe_d = pe_q;
    if (ini_err)     pe_d = 1'b1;
    else if (pe_clr) pe_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_OFF;
      pe_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      pe_q <= pe_d;
    end
  end

  assign perr_n  = (ph_q != PH_LOW);
  assign perr_oe = (ph_q != PH_OFF);
  assign pe_det  = pe_q;

  AST_PERR_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |=> (perr_n && perr_oe)); // R5
  AST_PERR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> perr_oe); // R5
  AST_PE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_q && !pe_clr) |=> pe_q); // R9
  AST_FAR_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (far_pass && !ini_err && !(pere_near && pere_far)) |=> perr_n); // R8
endmodule

// File: rtl/dw_parity_guard.sv
`timescale 1ns/1ps
module dw_parity_guard #(
  parameter  int AW = 32,
  parameter  int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_vld,
  input  logic [AW-1:0] ld_addr,
  input  logic [BW-1:0] ld_be,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_par,
  input  logic          cmp_vld,
  input  logic          cmp_far_perr,
  input  logic          req_vld,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] req_be,
  input  logic [DW-1:0] req_data,
  input  logic          par_in,
  input  logic          pere_near,
  input  logic          pere_far,
  input  logic          pe_det_clr,
  output logic          trdy_n,
  output logic          stop_n,
  output logic          perr_n,
  output logic          perr_oe,
  output logic          pe_det,
  output logic          st_ret,
  output logic          st_far_perr,
  output logic          ent_full
);
  logic          e_full, e_avail, e_far, e_par;
  logic [AW-1:0] e_addr;
  logic [BW-1:0] e_be;
  logic [DW-1:0] e_data;
  logic          ini_err, done, far_pass;

  dwp_entry #(.AW(AW), .DW(DW)) u_entry (
    .clk(clk), .rst_n(rst_n),
    .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_be(ld_be), .ld_data(ld_data), .ld_par(ld_par),
    .cmp_vld(cmp_vld), .cmp_far_perr(cmp_far_perr), .free(done),
    .e_full(e_full), .e_avail(e_avail), .e_far(e_far),
    .e_addr(e_addr), .e_be(e_be), .e_data(e_data), .e_par(e_par)
  );

  dwp_tgt #(.AW(AW), .DW(DW)) u_tgt (
    .clk(clk), .rst_n(rst_n),
    .req_vld(req_vld), .req_addr(req_addr), .req_be(req_be), .req_data(req_data),
    .par_in(par_in),
    .e_full(e_full), .e_avail(e_avail), .e_far(e_far),
    .e_addr(e_addr), .e_be(e_be), .e_data(e_data), .e_par(e_par),
    .trdy_n(trdy_n), .stop_n(stop_n),
    .ini_err(ini_err), .done(done), .far_pass(far_pass),
    .st_ret(st_ret), .st_far(st_far_perr)
  );

  dwp_perr u_perr (
    .clk(clk), .rst_n(rst_n),
    .ini_err(ini_err), .far_pass(far_pass),
    .pere_near(pere_near), .pere_far(pere_far), .pe_clr(pe_det_clr),
    .perr_n(perr_n), .perr_oe(perr_oe), .pe_det(pe_det)
  );

  assign ent_full = e_full;

  AST_RET_FREES_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    st_ret |-> !ent_full); // R7
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!trdy_n && !stop_n)); // R2
  AST_PE_SET_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ini_err |=> pe_det); // R4
endmodule

// File: tb/sim_dw_parity_guard.sv
`timescale 1ns/1ps
module sim_dw_parity_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_vld = 0, ld_par = 0, cmp_vld = 0, cmp_far_perr = 0;
  logic [31:0] ld_addr = '0, ld_data = '0, req_addr = '0, req_data = '0;
  logic [3:0]  ld_be = '0, req_be = '0;
  logic        req_vld = 0, par_in = 0, pere_near = 0, pere_far = 0, pe_det_clr = 0;
  logic        trdy_n, stop_n, perr_n, perr_oe, pe_det, st_ret, st_far_perr, ent_full;

  int n_chk = 0;
  int n_fail = 0;
  bit live = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  dw_parity_guard u0 (
    .clk(clk), .rst_n(rst_n),
    .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_be(ld_be), .ld_data(ld_data), .ld_par(ld_par),
    .cmp_vld(cmp_vld), .cmp_far_perr(cmp_far_perr),
    .req_vld(req_vld), .req_addr(req_addr), .req_be(req_be), .req_data(req_data),
    .par_in(par_in), .pere_near(pere_near), .pere_far(pere_far), .pe_det_clr(pe_det_clr),
    .trdy_n(trdy_n), .stop_n(stop_n), .perr_n(perr_n), .perr_oe(perr_oe),
    .pe_det(pe_det), .st_ret(st_ret), .st_far_perr(st_far_perr), .ent_full(ent_full)
  );

  function automatic logic par36(input logic [31:0] d, input logic [3:0] b);
    return ^{d, b};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  bit          m_full = 0, m_avail = 0, m_far = 0, m_par = 0, m_pe = 0;
  bit          m_ret = 0, m_retfar = 0, m_hit = 0;
  logic [31:0] m_addr = '0, m_data = '0, r_data = '0;
  logic [3:0]  m_be = '0, r_be = '0;
  int          tp = 0;
  int          pph = 0;

  always @(posedge clk) begin
    bit fire, set_pe, free_e, old_full;
    if (!rst_n) begin
      m_full = 0; m_avail = 0; m_far = 0; m_pe = 0; m_ret = 0; m_retfar = 0;
      tp = 0; pph = 0; m_hit = 0;
    end else begin
      old_full = m_full; fire = 0; set_pe = 0; free_e = 0; m_ret = 0; m_retfar = 0;
      if (pph == 1) pph = 2; else if (pph == 2) pph = 0;
      case (tp)
        0: if (req_vld) begin
             m_hit = m_full && m_avail && req_addr == m_addr && req_be == m_be;
             r_data = req_data; r_be = req_be; tp = 1;
           end
        1: tp = m_hit ? 2 : 0;
        default: begin
          tp = 0;
          if (par_in !== par36(r_data, r_be)) begin
            set_pe = 1; fire = pere_near;
          end else if (r_data == m_data && par_in == m_par) begin
            free_e = 1; m_ret = 1; m_retfar = m_far;
            fire = m_far && pere_near && pere_far;
          end
        end
      endcase
      if (fire) pph = 1;
      if (set_pe) m_pe = 1; else if (pe_det_clr) m_pe = 0;
      if (cmp_vld && old_full) begin m_avail = 1; m_far = cmp_far_perr; end
      if (free_e) begin m_full = 0; m_avail = 0; m_far = 0; end
      else if (ld_vld && !old_full) begin
        m_full = 1; m_avail = 0; m_far = 0;
        m_addr = ld_addr; m_be = ld_be; m_data = ld_data; m_par = ld_par;
      end
    end
  end

  always @(negedge clk) begin
    if (live && !ended) begin
      chk("R3 trdy_n", trdy_n, !(tp == 1 && m_hit));
      chk("R2 stop_n", stop_n, !(tp == 1 && !m_hit));
      chk("R5 perr_n", perr_n, !(pph == 1));
      chk("R5 perr_oe", perr_oe, pph != 0);
      chk("R4 pe_det", pe_det, m_pe);
      chk("R7 st_ret", st_ret, m_ret);
      chk("R8 st_far_perr", st_far_perr, m_retfar);
      chk("R6 ent_full", ent_full, m_full);
    end
  end

  task automatic load(input logic [31:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    ld_vld = 1; ld_addr = a; ld_be = b; ld_data = d; ld_par = par36(d, b);
    @(negedge clk);
    ld_vld = 0;
  endtask

  task automatic complete(input logic fp);
    @(negedge clk);
    cmp_vld = 1; cmp_far_perr = fp;
    @(negedge clk);
    cmp_vld = 0; cmp_far_perr = 0;
  endtask

  task automatic retry(input logic [31:0] a, input logic [3:0] b, input logic [31:0] d, input logic p);
    @(negedge clk);
    req_vld = 1; req_addr = a; req_be = b; req_data = d;
    @(negedge clk);
    req_vld = 0;
    @(negedge clk);
    par_in = p;
    @(negedge clk);
    par_in = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    finish_run();
  end

  localparam logic [31:0] A_ADDR = 32'h0000_1000;
  localparam logic [31:0] A_DATA = 32'hA5A5_0F0F;
  localparam logic [31:0] B_ADDR = 32'h0000_2040;
  localparam logic [31:0] B_DATA = 32'h1234_5678;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1 trdy_n", trdy_n, 1); chk("R1 stop_n", stop_n, 1);
    chk("R1 perr_n", perr_n, 1); chk("R1 perr_oe", perr_oe, 0);
    chk("R1 pe_det", pe_det, 0); chk("R1 st_ret", st_ret, 0);
    chk("R1 ent_full", ent_full, 0);
    live = 1;
    pere_near = 1; pere_far = 1;

    // R2: no entry held, then entry without completion
    retry(A_ADDR, 4'hF, A_DATA, par36(A_DATA, 4'hF));
    complete(1'b1);                     // R10: ignored, no entry
    load(A_ADDR, 4'hF, A_DATA);
    retry(A_ADDR, 4'hF, A_DATA, par36(A_DATA, 4'hF));
    complete(1'b0);
    // R2: address and byte-enable mismatch
    retry(A_ADDR + 32'h4, 4'hF, A_DATA, par36(A_DATA, 4'hF));
    retry(A_ADDR, 4'h3, A_DATA, par36(A_DATA, 4'h3));

    // R4 R5 R6: initiator parity error with near enable
    retry(A_ADDR, 4'hF, A_DATA, ~par36(A_DATA, 4'hF));
    chk("R6 entry kept after parity error", ent_full, 1);
    chk("R4 pe_det set", pe_det, 1);

    // R9: clear pulse
    @(negedge clk); pe_det_clr = 1;
    @(negedge clk); pe_det_clr = 0;
    chk("R9 pe_det cleared", pe_det, 0);

    // R6: data mismatch with correct parity
    retry(A_ADDR, 4'hF, A_DATA ^ 32'h1, par36(A_DATA ^ 32'h1, 4'hF));
    chk("R6 entry kept after data mismatch", ent_full, 1);

    // R4: parity error with near enable off, no PERR
    pere_near = 0;
    retry(A_ADDR, 4'hF, A_DATA, ~par36(A_DATA, 4'hF));
    chk("R4 pe_det set without enable", pe_det, 1);
    pere_near = 1;

    // R7: exact match returns status
    retry(A_ADDR, 4'hF, A_DATA, par36(A_DATA, 4'hF));
    chk("R7 entry freed", ent_full, 0);

    // R8: far error with far enable off
    load(B_ADDR, 4'h6, B_DATA);
    complete(1'b1);
    pere_far = 0;
    retry(B_ADDR, 4'h6, B_DATA, par36(B_DATA, 4'h6));

    // R8: far error with both enables; R10 load while full ignored
    load(A_ADDR, 4'hC, A_DATA);
    load(B_ADDR, 4'hF, B_DATA);
    complete(1'b1);
    pere_far = 1;
    retry(B_ADDR, 4'hF, B_DATA, par36(B_DATA, 4'hF));
    chk("R10 second load ignored", ent_full, 1);
    retry(A_ADDR, 4'hC, A_DATA, par36(A_DATA, 4'hC));
    chk("R8 entry freed after far error", ent_full, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule